// File: doc/BRIEF.md
# Narrow External Bus Width Adapter

The adapter sits between a 32-bit little-endian on-chip request port and an external memory whose data path is either 8 or 16 bits wide. Each accepted request carries a byte address, an access size (byte, halfword or word), a direction, write data and the width of the targeted device. The adapter works out which internal byte lanes are live and places them on the narrow external data pins. When the access is wider than the device, it issues a run of narrow beats. On reads it collects each beat's data into the matching internal lanes. One response then returns the whole word.

The external side is a one-beat-at-a-time valid/ready exchange. It stands in for the timing engine that owns chip selects and strobes. For a 16-bit device the adapter also drives a 2-bit active-low byte mask. Its external address is the halfword address, which is the byte address shifted right by one. For an 8-bit device the external address is the byte address itself.

Top module: `ebus_width_adapter`

## Requirements
- R1: Internal data is little-endian, with byte lane n in bits 8n+7:8n. For an 8-bit device, the lane given by byte address bits 1:0 is driven on ext_wdata_o[7:0], and ext_wdata_o[15:8] is zero.
- R2: For a 16-bit device, byte address bit 1 selects lanes 1:0 (bit 1 = 0) or lanes 3:2 (bit 1 = 1) for ext data [15:0]. Byte address bit 0 never changes which lanes are routed or which external address is used.
- R3: ext_be_no depends on the device and the access. For a byte write to a 16-bit device it is 2'b10 at an even address and 2'b01 at an odd address. For 16-bit halfword or word writes, and for all 16-bit reads, it is 2'b00. For an 8-bit device it is 2'b11.
- R4: ext_addr_o is the beat's byte address shifted right by one for a 16-bit device, and the byte address unchanged for an 8-bit device.
- R5: A word access to a 16-bit device takes two beats, lower halfword first. The beats are at byte addresses base and base+2, where base is the request address with bits 1:0 cleared.
- R6: On an 8-bit device, a word access takes four beats in ascending byte order from address & ~3. A halfword access takes two beats from address & ~1. A byte access takes one beat. A halfword access to a 16-bit device takes one beat.
- R7: A beat completes in the cycle in which ext_valid_o and ext_ready_i are both high. Until then ext_valid_o, ext_addr_o and ext_wdata_o hold steady.
- R8: rsp_valid_o pulses high for exactly one cycle, in the cycle right after the last beat completes. It pulses once per request.
- R9: On reads, each beat's data is written into its lanes of rsp_rdata_o. Lanes outside the request, including the unselected byte of a 16-bit byte read, read as zero. ext_rdata_i[15:8] is ignored for an 8-bit device.
- R10: req_ready_o is high only while no access is in progress. A request presented while busy is ignored and produces no beats.
- R11: After reset, req_ready_o is 1, and ext_valid_o and rsp_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Internal request present |
| req_ready_o | output | 1 | Adapter idle, request accepted this cycle if valid |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 32 | Internal write data |
| dev_x16_i | input | 1 | Target is 16 bits wide (else 8) |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Assembled read word |
| ext_valid_o | output | 1 | External beat pending |
| ext_ready_i | input | 1 | External beat completes |
| ext_addr_o | output | ADDR_W | Device address of the beat |
| ext_write_o | output | 1 | Beat direction |
| ext_wdata_o | output | 16 | Narrow write data |
| ext_be_no | output | 2 | Active-low byte mask |
| ext_rdata_i | input | 16 | Narrow read data |

## Verification
The bench targets lane steering at odd and high addresses. A design that used address bit 0 on a 16-bit device would send an odd byte to the wrong external address. Using the wrong bit for an 8-bit device would return the byte in a shifted lane. The bench checks the order and count of beats for word and halfword accesses on both widths, where a missed increment would repeat an address or a halfword. It checks byte-mask values for odd and even byte writes, where a swapped mask would corrupt the neighbouring byte in the device model. It also checks that unrequested lanes come back zero, that garbage on the upper external pins for 8-bit reads is ignored, that the response arrives exactly one cycle after the last beat, and that a request poked in mid-access is dropped.

// File: rtl/ebwa_pkg.sv
package ebwa_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned EXT_W  = 16;
  localparam int unsigned IDX_W  = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  // last beat index for a given device width and size
  function automatic logic [IDX_W-1:0] last_beat(input logic x16, input logic [1:0] sz);
    if (x16) return (sz[1]) ? 2'd1 : 2'd0;
    if (sz[1]) return 2'd3;
    return (sz == SZ_HALF) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [LANES-1:0] req_lanes(input logic [1:0] sz, input logic [1:0] off);
    if (sz[1]) return 4'b1111;
    if (sz == SZ_HALF) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b0001 << off;
  endfunction
endpackage

// File: rtl/ebwa_lane_map.sv
module ebwa_lane_map
  import ebwa_pkg::*;
(
  input  logic              dev_x16_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  input  logic [1:0]        req_off_i,
  input  logic [1:0]        beat_off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [EXT_W-1:0]  ext_rdata_i,
  output logic [EXT_W-1:0]  ext_wdata_o,
  output logic [1:0]        ext_be_no,
  output logic [LANES-1:0]  fill_lanes_o,
  output logic [DATA_W-1:0] fill_data_o
);
  logic [LANES-1:0] beat_lanes;

  always_comb begin
    if (dev_x16_i) begin
      beat_lanes  = beat_off_i[1] ? 4'b1100 : 4'b0011;
      ext_wdata_o = beat_off_i[1] ? wdata_i[31:16] : wdata_i[15:0];
      fill_data_o = {2{ext_rdata_i}};
      if (write_i && size_i == SZ_BYTE)
        ext_be_no = req_off_i[0] ? 2'b01 : 2'b10;
      else
        ext_be_no = 2'b00;
    end else begin
      beat_lanes  = 4'b0001 << beat_off_i;
      ext_wdata_o = {8'h00, wdata_i[8*beat_off_i +: 8]};
      fill_data_o = {LANES{ext_rdata_i[7:0]}};
      ext_be_no   = 2'b11;
    end
    fill_lanes_o = beat_lanes & req_lanes(size_i, req_off_i);
  end
endmodule

// File: rtl/ebwa_beat_seq.sv
module ebwa_beat_seq
  import ebwa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dev_x16_i,
  input  logic [1:0]       size_i,
  input  logic             ext_ready_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hs_o,
  output logic             done_o,
  output logic             rsp_o
);
  logic             busy_q, rsp_q;
  logic [IDX_W-1:0] idx_q, last_q;

  assign hs_o   = busy_q & ext_ready_i;
  assign done_o = hs_o && (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= done_o;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        last_q <= last_beat(dev_x16_i, size_i);
      end else if (hs_o) begin
        if (done_o) busy_q <= 1'b0;
        else        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign rsp_o  = rsp_q;

  // R8
  rsp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_q |=> !rsp_q);
  // R10
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/ebwa_rd_assemble.sv
module ebwa_rd_assemble
  import ebwa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fill_en_i,
  input  logic [LANES-1:0]  lanes_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     lane_q <= '0;
      else if (clear_i)                lane_q <= '0;
      else if (fill_en_i && lanes_i[g]) lane_q <= data_i[8*g +: 8];
    end
    assign rdata_o[8*g +: 8] = lane_q;
  end

  // R9
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> rdata_o == '0);
endmodule

// File: rtl/ebus_width_adapter.sv
module ebus_width_adapter
  import ebwa_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_write_i,
  input  logic [31:0]       req_wdata_i,
  input  logic              dev_x16_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              ext_valid_o,
  input  logic              ext_ready_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              ext_write_o,
  output logic [15:0]       ext_wdata_o,
  output logic [1:0]        ext_be_no,
  input  logic [15:0]       ext_rdata_i
);
  logic              busy, start, hs, done;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_q, base, beat_addr;
  logic [1:0]        size_q;
  logic              write_q, x16_q;
  logic [31:0]       wdata_q, fill_data;
  logic [LANES-1:0]  fill_lanes;

  assign req_ready_o = !busy;
  assign start       = req_valid_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
      x16_q   <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      size_q  <= req_size_i;
      write_q <= req_write_i;
      x16_q   <= dev_x16_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_comb begin
    base = addr_q;
    if (size_q[1])            base[1:0] = 2'b00;
    else if (size_q == SZ_HALF) base[0] = 1'b0;
    beat_addr = base + (ADDR_W'(idx) << x16_q);
  end

  ebwa_beat_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .dev_x16_i   (dev_x16_i),
    .size_i      (req_size_i),
    .ext_ready_i (ext_ready_i),
    .busy_o      (busy),
    .idx_o       (idx),
    .hs_o        (hs),
    .done_o      (done),
    .rsp_o       (rsp_valid_o)
  );

  ebwa_lane_map u_map (
    .dev_x16_i    (x16_q),
    .size_i       (size_q),
    .write_i      (write_q),
    .req_off_i    (addr_q[1:0]),
    .beat_off_i   (beat_addr[1:0]),
    .wdata_i      (wdata_q),
    .ext_rdata_i  (ext_rdata_i),
    .ext_wdata_o  (ext_wdata_o),
    .ext_be_no    (ext_be_no),
    .fill_lanes_o (fill_lanes),
    .fill_data_o  (fill_data)
  );

  ebwa_rd_assemble u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .fill_en_i (hs && !write_q),
    .lanes_i   (fill_lanes),
    .data_i    (fill_data),
    .rdata_o   (rsp_rdata_o)
  );

  assign ext_valid_o = busy;
  assign ext_write_o = write_q;
  assign ext_addr_o  = x16_q ? {1'b0, beat_addr[ADDR_W-1:1]} : beat_addr;

  // R7
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && !ext_ready_i) |=>
      (ext_valid_o && $stable(ext_addr_o) && $stable(ext_wdata_o)));
  // R10
  ready_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && ext_valid_o));
  // R8
  rsp_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(ext_valid_o && ext_ready_i));
  // R5
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !done) |=> (ext_valid_o && ext_addr_o == $past(ext_addr_o) + 1'b1));
  // R3
  x8_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && !x16_q) |-> ext_be_no == 2'b11);
endmodule

// File: tb/ebus_width_adapter_tb_top.sv
module ebus_width_adapter_tb_top;
  localparam int AW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_size_i = '0;
  logic          req_write_i = 1'b0;
  logic [31:0]   req_wdata_i = '0;
  logic          dev_x16_i = 1'b0;
  logic          rsp_valid_o;
  logic [31:0]   rsp_rdata_o;
  logic          ext_valid_o;
  logic          ext_ready_i = 1'b0;
  logic [AW-1:0] ext_addr_o;
  logic          ext_write_o;
  logic [15:0]   ext_wdata_o;
  logic [1:0]    ext_be_no;
  logic [15:0]   ext_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  ebus_width_adapter #(.ADDR_W(AW)) dut_i (.*);

  int tests = 0, fails = 0;
  logic [7:0]    mem [256];
  logic [AW-1:0] log_addr [8];
  logic [1:0]    log_be [8];
  logic [15:0]   log_wd [8];
  int nlog = 0, dev_wait = 0, wcnt = 0, ncnt = 0;
  int rsp_cnt = 0, rsp_n = 0, hs_n = 0, hold_err = 0;
  logic [AW-1:0] hold_addr = '0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // external device model, acts on falling edges
  always @(negedge clk_i) begin
    ncnt++;
    if (rsp_valid_o) begin rsp_cnt++; rsp_n = ncnt; end
    if (ext_ready_i) begin
      ext_ready_i = 1'b0;
      wcnt = 0;
    end else if (ext_valid_o) begin
      if (wcnt == 0) hold_addr = ext_addr_o;
      else if (ext_addr_o !== hold_addr) hold_err++;
      if (wcnt >= dev_wait) begin
        if (nlog < 8) begin
          log_addr[nlog] = ext_addr_o; log_be[nlog] = ext_be_no; log_wd[nlog] = ext_wdata_o;
        end
        nlog++;
        if (dev_x16_i) begin
          if (ext_write_o) begin
            if (!ext_be_no[0]) mem[8'(ext_addr_o*2)]   = ext_wdata_o[7:0];
            if (!ext_be_no[1]) mem[8'(ext_addr_o*2+1)] = ext_wdata_o[15:8];
          end
          ext_rdata_i = {mem[8'(ext_addr_o*2+1)], mem[8'(ext_addr_o*2)]};
        end else begin
          if (ext_write_o) mem[8'(ext_addr_o)] = ext_wdata_o[7:0];
          ext_rdata_i = {8'hA5, mem[8'(ext_addr_o)]};
        end
        ext_ready_i = 1'b1;
        hs_n = ncnt;
      end else wcnt++;
    end
  end

  task automatic access(input bit x16, input logic [AW-1:0] a, input logic [1:0] sz,
                        input bit wr, input logic [31:0] wd, input bit poke,
                        output logic [31:0] rd);
    int c0, to;
    @(negedge clk_i);
    nlog = 0; c0 = rsp_cnt;
    dev_x16_i = x16; req_addr_i = a; req_size_i = sz; req_write_i = wr; req_wdata_i = wd;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (poke) begin
      req_addr_i = 24'h80; req_write_i = 1'b1; req_size_i = 2'd0; req_valid_i = 1'b1;
      for (int i = 0; i < 2; i++) begin
        @(negedge clk_i); #1;
        chk("R10", "ready while busy", 32'(req_ready_o), 32'd0);
      end
      req_valid_i = 1'b0;
    end
    to = 0;
    while (!rsp_valid_o && to < 300) begin @(negedge clk_i); to++; end
    #1;
    rd = rsp_rdata_o;
    chk("R8", "rsp one cycle after last beat", 32'(rsp_n), 32'(hs_n + 1));
    @(negedge clk_i); #1;
    chk("R8", "single rsp pulse", 32'(rsp_cnt - c0), 32'd1);
  endtask

  task automatic t_reset();
    chk("R11", "ready at reset", 32'(req_ready_o), 32'd1);
    chk("R11", "ext_valid at reset", 32'(ext_valid_o), 32'd0);
    chk("R11", "rsp_valid at reset", 32'(rsp_valid_o), 32'd0);
  endtask

  task automatic t_x16_word();
    logic [31:0] rd;
    dev_wait = 2;
    access(1, 24'h10, 2'd2, 1, 32'h44332211, 0, rd);
    chk("R5", "beats", 32'(nlog), 32'd2);
    chk("R4", "beat0 addr", 32'(log_addr[0]), 32'h8);
    chk("R5", "beat1 addr", 32'(log_addr[1]), 32'h9);
    chk("R5", "low half first", 32'(log_wd[0]), 32'h2211);
    chk("R5", "high half second", 32'(log_wd[1]), 32'h4433);
    chk("R3", "word write mask", 32'(log_be[0]), 32'd0);
    chk("R1", "mem bytes", {mem[8'h13], mem[8'h12], mem[8'h11], mem[8'h10]}, 32'h44332211);
    access(1, 24'h12, 2'd2, 0, 32'h0, 0, rd);
    chk("R9", "x16 word read", rd, 32'h44332211);
    chk("R5", "read base aligned", 32'(log_addr[0]), 32'h8);
  endtask

  task automatic t_x16_byte();
    logic [31:0] rd;
    dev_wait = 1;
    mem[8'h20] = 8'h5A; mem[8'h21] = 8'h00; mem[8'h22] = 8'h77; mem[8'h23] = 8'h88;
    access(1, 24'h21, 2'd0, 1, 32'h0000CC00, 0, rd);
    chk("R3", "odd byte mask", 32'(log_be[0]), 32'h1);
    chk("R2", "odd byte addr", 32'(log_addr[0]), 32'h10);
    chk("R3", "odd byte written", 32'(mem[8'h21]), 32'hCC);
    chk("R3", "even neighbour kept", 32'(mem[8'h20]), 32'h5A);
    access(1, 24'h20, 2'd0, 1, 32'hFFFFFFE7, 0, rd);
    chk("R3", "even byte mask", 32'(log_be[0]), 32'h2);
    chk("R3", "odd neighbour kept", 32'(mem[8'h21]), 32'hCC);
    chk("R3", "even byte written", 32'(mem[8'h20]), 32'hE7);
    access(1, 24'h21, 2'd0, 0, 32'h0, 0, rd);
    chk("R9", "x16 byte read lane1", rd, 32'h0000CC00);
    chk("R3", "read mask", 32'(log_be[0]), 32'd0);
    access(1, 24'h23, 2'd0, 0, 32'h0, 0, rd);
    chk("R2", "x16 byte read lane3", rd, 32'h88000000);
    chk("R2", "bit0 ignored for addr", 32'(log_addr[0]), 32'h11);
    access(1, 24'h22, 2'd0, 0, 32'h0, 0, rd);
    chk("R9", "x16 byte read lane2", rd, 32'h00770000);
    chk("R2", "same halfword addr", 32'(log_addr[0]), 32'h11);
  endtask

  task automatic t_x16_half();
    logic [31:0] rd;
    dev_wait = 0;
    access(1, 24'h32, 2'd1, 1, 32'hBEEF1234, 0, rd);
    chk("R6", "x16 half beats", 32'(nlog), 32'd1);
    chk("R2", "upper half routed", 32'(log_wd[0]), 32'hBEEF);
    chk("R4", "half addr", 32'(log_addr[0]), 32'h19);
    chk("R2", "mem upper half", {mem[8'h33], mem[8'h32]}, 32'hBEEF);
    chk("R2", "lower half untouched", {mem[8'h31], mem[8'h30]}, 32'h0);
    access(1, 24'h32, 2'd1, 0, 32'h0, 0, rd);
    chk("R9", "x16 half read", rd, 32'hBEEF0000);
  endtask

  task automatic t_x8_word();
    logic [31:0] rd;
    dev_wait = 0;
    access(0, 24'h41, 2'd2, 1, 32'hDDCCBBAA, 0, rd);
    chk("R6", "x8 word beats", 32'(nlog), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R6", "x8 ascending addr", 32'(log_addr[i]), 32'h40 + i);
      chk("R3", "x8 mask", 32'(log_be[i]), 32'h3);
    end
    chk("R1", "lane2 on low pins, upper zero", 32'(log_wd[2]), 32'h00CC);
    chk("R1", "mem bytes", {mem[8'h43], mem[8'h42], mem[8'h41], mem[8'h40]}, 32'hDDCCBBAA);
    access(0, 24'h40, 2'd2, 0, 32'h0, 0, rd);
    chk("R9", "x8 word read ignores upper pins", rd, 32'hDDCCBBAA);
  endtask

  task automatic t_x8_half_byte();
    logic [31:0] rd;
    dev_wait = 1;
    access(0, 24'h43, 2'd1, 0, 32'h0, 0, rd);
    chk("R9", "x8 half read", rd, 32'hDDCC0000);
    chk("R6", "x8 half beats", 32'(nlog), 32'd2);
    chk("R6", "x8 half first addr", 32'(log_addr[0]), 32'h42);
    chk("R6", "x8 half second addr", 32'(log_addr[1]), 32'h43);
    access(0, 24'h41, 2'd0, 0, 32'h0, 0, rd);
    chk("R1", "x8 byte read lane1", rd, 32'h0000BB00);
    access(0, 24'h47, 2'd0, 1, 32'h99000000, 0, rd);
    chk("R1", "lane3 on low pins", 32'(log_wd[0]), 32'h0099);
    chk("R4", "x8 byte addr", 32'(log_addr[0]), 32'h47);
    chk("R1", "x8 byte stored", 32'(mem[8'h47]), 32'h99);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] rd;
    dev_wait = 3;
    access(0, 24'h50, 2'd2, 1, 32'h87654321, 1, rd);
    chk("R10", "no extra beats", 32'(nlog), 32'd4);
    chk("R10", "first addr kept", 32'(log_addr[0]), 32'h50);
    chk("R10", "last addr kept", 32'(log_addr[3]), 32'h53);
    chk("R10", "poked byte untouched", 32'(mem[8'h80]), 32'h0);
    chk("R7", "addr held while waiting", 32'(hold_err), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    t_x16_word();
    t_x16_byte();
    t_x16_half();
    t_x8_word();
    t_x8_half_byte();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule